// File: doc/BRIEF.md
# Oversampled Encoder Field Receiver

This block takes the response of an absolute position encoder from a half-duplex serial line and turns it into payload words. The line reaches the block as one sample per clock, taken at a selectable rate of 8, 6 or 4 samples per bit. A response is a run of fixed-size fields. Each field opens with a low start bit, carries 16 payload bits and closes with a high delimiter bit. The first field is the information field. One or more data fields follow it. The caller knows from its command code how many fields to expect.

After a start request, the block searches for each start bit and times the rest of the field from the first low sample. It publishes every field as a one-cycle word strobe. While it receives, it updates an 8-bit CRC over the payload bits. The framing bits and the final byte of the last field stay out of that CRC, because that byte is the check value sent by the encoder. When the expected number of fields has arrived, the block reports the computed CRC, the received CRC and whether they match. The response ends early if a delimiter is low (framing error) or if the line stays idle for too long while a start bit is awaited (timeout).

Top module: `enc_field_rx`

## Requirements
- R1: After reset, `busy`, `done`, `field_valid`, `crc_ok`, `frame_err` and `timeout_err` are all 0.
- R2: A `start` pulse is accepted only while `busy` is 0. In the cycle after it is accepted, `busy` is 1 and `crc_ok`, `frame_err` and `timeout_err` are 0. The block captures `os_sel`, `field_count` and `timeout_limit` at that time. A `start` pulse while `busy` is 1 has no effect.
- R3: A field is one low start bit, then 16 payload bits sent most significant first, then a high delimiter bit. Each bit is N samples long, with N set by `os_sel`: 0 gives 8, 1 gives 6, 2 gives 4 and 3 gives 8. Bit k of a field is sampled N*k + N/2 samples after the first low sample seen while a start bit is awaited.
- R4: A low sample does not begin a field if the line is high again at its start-bit sample point. The search for a start bit then continues.
- R5: `field_valid` pulses for one cycle in the cycle after the delimiter sample of each good field. `field_data` then holds the payload and `field_idx` holds the field number, counting from 0.
- R6: A response holds `field_count` fields, and a count of 0 is treated as 1. `done` pulses for one cycle when the response ends, in the same cycle as the last `field_valid`, and `busy` falls with it.
- R7: `crc_calc` is the CRC with polynomial x^8+x^2+x+1 (0x07) and initial value 0x00, shifted in most significant bit first. It covers all payload bits of all fields except the low 8 payload bits of the last field.
- R8: On a complete response, `crc_rx` is the low byte of the last field's payload, and `crc_ok` is 1 exactly when `crc_rx` equals `crc_calc`.
- R9: A low delimiter raises `frame_err` together with `done` in the cycle after its sample point. No `field_valid` is issued for that field and the response ends.
- R10: While a start bit is awaited, `timeout_limit` consecutive high samples (a limit of 0 counts as 1) raise `timeout_err` together with `done`. The count starts again for every field.
- R11: `crc_ok`, `crc_rx`, `frame_err` and `timeout_err` hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin receiving a response |
| os_sel | input | 2 | Samples per bit: 0→8, 1→6, 2→4, 3→8 |
| field_count | input | FCW (4) | Number of fields in the response |
| timeout_limit | input | TOW (16) | Idle samples allowed while awaiting a start bit |
| line_in | input | 1 | Oversampled line, idle high |
| busy | output | 1 | Response in progress |
| field_valid | output | 1 | Strobe for a received field |
| field_idx | output | FCW (4) | Number of the strobed field |
| field_data | output | 16 | Payload of the strobed field |
| done | output | 1 | Response finished (pulse) |
| crc_ok | output | 1 | Computed CRC equals received CRC |
| crc_calc | output | 8 | Computed CRC |
| crc_rx | output | 8 | Received CRC byte |
| frame_err | output | 1 | Low delimiter seen |
| timeout_err | output | 1 | No start bit within the limit |

## Verification
On every cycle, the assertions check these properties. `done` is a single-cycle pulse that coincides with the end of `busy`. The two error flags are never both set. No word strobe accompanies a failed end of response. Strobed field numbers stay below the captured count. The match flag agrees with the two CRC bytes. Results are stable while the block is idle. An accepted start always makes the block busy.

Only the bench scenarios can show the sample-point timing at each oversampling factor, the payload values, the CRC value and which bits it excludes, the rejection of a start glitch, and the exact cycles at which a framing error or timeout ends a response. The bench compares the strobes on every clock against a schedule it computes from the samples it sends.

// File: rtl/enc_rx_pkg.sv
// Package: shared types, field geometry and helper functions for the
// oversampled encoder field receiver. Assumes an 8-bit CRC shifted MSB first.
package enc_rx_pkg;

    localparam int FIELD_PAY_W  = 16;               // payload bits per field
    localparam int CRC_W        = 8;                // CRC width
    localparam int BIT_START    = 0;                // index of the start bit
    localparam int BIT_PAY_LO   = 1;                // first payload bit index
    localparam int BIT_PAY_HI   = FIELD_PAY_W;      // last payload bit index
    localparam int BIT_DELIM    = FIELD_PAY_W + 1;  // delimiter bit index
    localparam int BIT_CHK_LO   = FIELD_PAY_W - CRC_W + 1; // first check-byte bit

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_BITS = 2'd2
    } rx_state_t;

    // Map the oversampling selector to samples per bit.
    function automatic logic [3:0] os_factor(input logic [1:0] sel);
        case (sel)
            2'd1:    return 4'd6;
            2'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // One MSB-first CRC step for a single input bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic             b,
                                                  input logic [CRC_W-1:0] poly);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : {CRC_W{1'b0}});
    endfunction

endpackage

// File: rtl/enc_rx_bit_timer.sv
// Bit timer: counts samples inside the current field and raises a strobe at
// the middle sample of each bit. Assumes 'load' marks the first low sample of
// a start bit (sample 0) and that 'run' stays high while a field is timed.
module enc_rx_bit_timer #(
    parameter int PHW = 4,
    parameter int BIW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           load,
    input  logic [PHW-1:0] os_n,
    output logic           mid,
    output logic [BIW-1:0] bit_idx
);
    logic           active;
    logic [PHW-1:0] ph;
    logic [PHW-1:0] half;

    assign half    = os_n >> 1;
    assign mid     = active && (ph == half);

    // Sample phase and bit index counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active  <= 1'b0;
            ph      <= '0;
            bit_idx <= '0;
        end else if (load) begin
            active  <= 1'b1;
            ph      <= PHW'(1);
            bit_idx <= '0;
        end else if (active) begin
            if (ph == os_n - PHW'(1)) begin
                ph      <= '0;
                bit_idx <= bit_idx + BIW'(1);
            end else begin
                ph      <= ph + PHW'(1);
            end
        end
    end
endmodule

// File: rtl/enc_rx_crc.sv
// Running CRC over single bits, MSB first. Assumes 'clr' and 'en' are never
// needed in the same cycle; 'clr' wins if they are.
module enc_rx_crc
    import enc_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 8'h07,
    parameter logic [CRC_W-1:0] INIT = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    // CRC register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= INIT;
        else if (en)       crc <= crc_step(crc, din, POLY);
    end
endmodule

// File: rtl/enc_field_rx.sv
// Top: receives a multi-field encoder response from an oversampled line.
// Hunts for each start bit, times the field with the bit timer, shifts in
// payload, checks the delimiter, feeds the CRC and ends the response on
// count, framing error or timeout. Assumes one line sample per clock, idle high.
module enc_field_rx
    import enc_rx_pkg::*;
#(
    parameter logic [7:0] CRC_POLY = 8'h07,
    parameter logic [7:0] CRC_INIT = 8'h00,
    parameter int         FCW      = 4,
    parameter int         TOW      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             os_sel,
    input  logic [FCW-1:0]         field_count,
    input  logic [TOW-1:0]         timeout_limit,
    input  logic                   line_in,
    output logic                   busy,
    output logic                   field_valid,
    output logic [FCW-1:0]         field_idx,
    output logic [FIELD_PAY_W-1:0] field_data,
    output logic                   done,
    output logic                   crc_ok,
    output logic [CRC_W-1:0]       crc_calc,
    output logic [CRC_W-1:0]       crc_rx,
    output logic                   frame_err,
    output logic                   timeout_err
);
    localparam int PHW = 4;
    localparam int BIW = $clog2(BIT_DELIM + 1);

    rx_state_t              state;
    logic [PHW-1:0]         os_q;
    logic [FCW-1:0]         last_idx;
    logic [FCW-1:0]         fidx;
    logic [TOW-1:0]         tlim_q;
    logic [TOW-1:0]         tcnt;
    logic [TOW:0]           tnext;
    logic [FIELD_PAY_W-1:0] shreg;
    logic                   accept, load, run, mid, is_last, crc_en, timeout_hit;
    logic                   in_pay, in_chk;
    logic [BIW-1:0]         bidx;

    // Control decode for this cycle.
    always_comb begin
        accept      = start && (state == RX_IDLE);
        load        = (state == RX_HUNT) && !line_in;
        run         = load || (state == RX_BITS);
        is_last     = (fidx == last_idx);
        in_pay      = (bidx >= BIW'(BIT_PAY_LO)) && (bidx <= BIW'(BIT_PAY_HI));
        in_chk      = (bidx >= BIW'(BIT_CHK_LO)) && is_last;
        crc_en      = (state == RX_BITS) && mid && in_pay && !in_chk;
        tnext       = {1'b0, tcnt} + (TOW+1)'(1);
        timeout_hit = tnext >= {1'b0, tlim_q};
    end

    assign busy = (state != RX_IDLE);

    enc_rx_bit_timer #(.PHW(PHW), .BIW(BIW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .load    (load),
        .os_n    (os_q),
        .mid     (mid),
        .bit_idx (bidx)
    );

    enc_rx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (crc_en),
        .din   (line_in),
        .crc   (crc_calc)
    );

    // Response sequencer: hunt, field timing, result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            os_q        <= 4'd8;
            last_idx    <= '0;
            fidx        <= '0;
            tlim_q      <= '0;
            tcnt        <= '0;
            shreg       <= '0;
            field_valid <= 1'b0;
            field_idx   <= '0;
            field_data  <= '0;
            done        <= 1'b0;
            crc_ok      <= 1'b0;
            crc_rx      <= '0;
            frame_err   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            field_valid <= 1'b0;
            done        <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (start) begin
                        os_q        <= os_factor(os_sel);
                        last_idx    <= (field_count == '0) ? '0 : field_count - FCW'(1);
                        tlim_q      <= timeout_limit;
                        fidx        <= '0;
                        tcnt        <= '0;
                        crc_ok      <= 1'b0;
                        frame_err   <= 1'b0;
                        timeout_err <= 1'b0;
                        state       <= RX_HUNT;
                    end
                end
                RX_HUNT: begin
                    if (!line_in) begin
                        state <= RX_BITS;
                    end else if (timeout_hit) begin
                        timeout_err <= 1'b1;
                        done        <= 1'b1;
                        state       <= RX_IDLE;
                    end else begin
                        tcnt <= tnext[TOW-1:0];
                    end
                end
                RX_BITS: begin
                    if (mid) begin
                        if (bidx == BIW'(BIT_START)) begin
                            if (line_in) state <= RX_HUNT;
                        end else if (in_pay) begin
                            shreg <= {shreg[FIELD_PAY_W-2:0], line_in};
                        end else if (bidx == BIW'(BIT_DELIM)) begin
                            if (!line_in) begin
                                frame_err <= 1'b1;
                                done      <= 1'b1;
                                state     <= RX_IDLE;
                            end else begin
                                field_valid <= 1'b1;
                                field_data  <= shreg;
                                field_idx   <= fidx;
                                if (is_last) begin
                                    crc_rx <= shreg[CRC_W-1:0];
                                    crc_ok <= (crc_calc == shreg[CRC_W-1:0]);
                                    done   <= 1'b1;
                                    state  <= RX_IDLE;
                                end else begin
                                    fidx  <= fidx + FCW'(1);
                                    tcnt  <= '0;
                                    state <= RX_HUNT;
                                end
                            end
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/enc_rx_checker.sv
// Checker: temporal properties of the field receiver's ports. Keeps its own
// copy of the accepted field count to bound the strobed field number.
module enc_rx_checker #(
    parameter int FCW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic [FCW-1:0] field_count,
    input logic           field_valid,
    input logic [FCW-1:0] field_idx,
    input logic           done,
    input logic           crc_ok,
    input logic [7:0]     crc_calc,
    input logic [7:0]     crc_rx,
    input logic           frame_err,
    input logic           timeout_err
);
    logic [FCW:0] cnt_q;

    // Count captured at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start && !busy) cnt_q <= (field_count == '0) ? (FCW+1)'(1) : {1'b0, field_count};
    end

    a_r2_start_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && timeout_err));
    a_r9_no_word_on_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_err) |-> !field_valid);
    a_r10_no_word_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_err) |-> !field_valid);
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        field_valid |-> ({1'b0, field_idx} < cnt_q));
    a_r8_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !frame_err && !timeout_err) |-> (crc_ok == (crc_calc == crc_rx)));
    a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(crc_ok) && $stable(crc_rx) &&
                               $stable(frame_err) && $stable(timeout_err)));
endmodule

bind enc_field_rx enc_rx_checker #(.FCW(FCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .field_count (field_count),
    .field_valid (field_valid),
    .field_idx   (field_idx),
    .done        (done),
    .crc_ok      (crc_ok),
    .crc_calc    (crc_calc),
    .crc_rx      (crc_rx),
    .frame_err   (frame_err),
    .timeout_err (timeout_err)
);

// File: tb/sim_enc_field_rx.sv
// Bench: builds each response as a sample queue, derives from it the cycle of
// every expected strobe, and compares the strobes on every clock.
module sim_enc_field_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  os_sel = 2'd0;
    logic [3:0]  field_count = 4'd1;
    logic [15:0] timeout_limit = 16'd1000;
    logic        line_in = 1'b1;
    logic        busy, field_valid, done, crc_ok, frame_err, timeout_err;
    logic [3:0]  field_idx;
    logic [15:0] field_data;
    logic [7:0]  crc_calc, crc_rx;

    int checks = 0, errors = 0, cyc = 0;
    bit armed = 0, finished = 0;
    logic [15:0] exp_word[int];
    logic [3:0]  exp_num[int];
    int          exp_done_cyc = -1;
    bit e_ferr, e_terr, e_full, e_ok;
    logic [7:0] e_calc, e_rx;
    string tag = "";

    enc_field_rx u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .os_sel(os_sel),
        .field_count(field_count), .timeout_limit(timeout_limit), .line_in(line_in),
        .busy(busy), .field_valid(field_valid), .field_idx(field_idx),
        .field_data(field_data), .done(done), .crc_ok(crc_ok), .crc_calc(crc_calc),
        .crc_rx(crc_rx), .frame_err(frame_err), .timeout_err(timeout_err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    // Reference CRC: polynomial long division bit by bit.
    function automatic logic [7:0] ref_crc(input bit bits[$]);
        int r = 0;
        foreach (bits[i]) begin
            r = (r << 1) | 0;
            if (((r >> 8) & 1) != bits[i]) r = r ^ 9'h107 ^ 9'h100 ^ 9'h100;
            r = r & 8'hFF;
        end
        return 8'(r);
    endfunction

    // Per-clock comparison of strobes and results.
    always @(negedge clk) begin
        if (armed) begin
            bit fv_e, dn_e;
            fv_e = exp_word.exists(cyc);
            dn_e = (cyc == exp_done_cyc);
            chk(field_valid === fv_e, "R5 field_valid", field_valid, fv_e);
            if (fv_e && field_valid) begin
                chk(field_data === exp_word[cyc], "R3/R5 field_data", field_data, exp_word[cyc]);
                chk(field_idx === exp_num[cyc], "R5 field_idx", field_idx, exp_num[cyc]);
            end
            chk(done === dn_e, "R6 done", done, dn_e);
            if (dn_e && done) begin
                chk(busy === 1'b0, "R6 busy at done", busy, 0);
                chk(frame_err === e_ferr, "R9 frame_err", frame_err, e_ferr);
                chk(timeout_err === e_terr, "R10 timeout_err", timeout_err, e_terr);
                if (e_full) begin
                    chk(crc_calc === e_calc, "R7 crc_calc", crc_calc, e_calc);
                    chk(crc_rx === e_rx, "R8 crc_rx", crc_rx, e_rx);
                    chk(crc_ok === e_ok, "R8 crc_ok", crc_ok, e_ok);
                end
            end
        end
    end

    task automatic run_case(input int sel, input int fc, input int nsend, input int bad,
                            input bit glitch, input int mid_start, input int tlim,
                            input bit good_crc, input int seed, input string name);
        bit smp[$];
        bit cbits[$];
        logic [15:0] pl[16];
        int osn, half, fce, p, s, x, xl;
        logic [7:0] cv;
        osn  = (sel == 1) ? 6 : (sel == 2) ? 4 : 8;
        half = osn / 2;
        fce  = (fc == 0) ? 1 : fc;
        tag  = name;
        for (int f = 0; f < 16; f++) pl[f] = 16'((seed + f * 7919) * 40503) ^ 16'h5A3C;
        for (int f = 0; f < fce; f++)
            for (int b = 15; b >= 0; b--)
                if (f < fce - 1 || b >= 8) cbits.push_back(pl[f][b]);
        cv = ref_crc(cbits);
        pl[fce-1][7:0] = good_crc ? cv : (cv ^ 8'h3C);
        repeat (5) smp.push_back(1'b1);
        if (glitch) begin
            smp.push_back(1'b0);
            repeat (osn) smp.push_back(1'b1);
        end
        @(negedge clk);
        p = cyc + 1;
        os_sel = 2'(sel); field_count = 4'(fc); timeout_limit = 16'(tlim);
        start = 1'b1; line_in = 1'b1;
        e_ferr = 0; e_terr = 0; e_full = 0; e_ok = 0; e_calc = cv; e_rx = pl[fce-1][7:0];
        xl = -1;
        for (int f = 0; f < nsend; f++) begin
            s = smp.size();
            repeat (osn) smp.push_back(1'b0);
            for (int b = 15; b >= 0; b--) repeat (osn) smp.push_back(pl[f][b]);
            repeat (osn) smp.push_back(f == bad ? 1'b0 : 1'b1);
            repeat (3) smp.push_back(1'b1);
            x = p + 1 + s + 17 * osn + half;
            if (f == bad) begin
                exp_done_cyc = x; e_ferr = 1;
                break;
            end
            exp_word[x] = pl[f]; exp_num[x] = 4'(f); xl = x;
            if (f == fce - 1) begin
                exp_done_cyc = x; e_full = 1; e_ok = good_crc;
            end
        end
        if (nsend < fce && bad < 0) begin
            e_terr = 1;
            exp_done_cyc = (xl < 0) ? p + ((tlim == 0) ? 1 : tlim) : xl + tlim;
        end
        for (int i = 0; i < smp.size(); i++) begin
            @(negedge clk);
            if (i == 0) begin
                chk(busy === 1'b1, "R2 busy after start", busy, 1);
                chk(!frame_err && !timeout_err && !crc_ok, "R2 results cleared",
                    {frame_err, timeout_err, crc_ok}, 0);
            end
            start   = (i == mid_start);
            line_in = smp[i];
        end
        @(negedge clk);
        start = 1'b0; line_in = 1'b1;
        while (cyc <= exp_done_cyc + 2) @(negedge clk);
        chk(frame_err === e_ferr && timeout_err === e_terr, "R11 flags held",
            {frame_err, timeout_err}, {e_ferr, e_terr});
        if (e_full) chk(crc_ok === e_ok && crc_rx === e_rx, "R11 crc held",
                        {crc_ok, crc_rx}, {e_ok, e_rx});
        exp_word.delete(); exp_num.delete(); exp_done_cyc = -1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !field_valid && !crc_ok && !frame_err && !timeout_err,
            "R1 reset state", {busy, done, field_valid, crc_ok, frame_err, timeout_err}, 0);
        armed = 1;
        run_case(0, 2, 2, -1, 0, -1, 1000, 1, 11, "R3 x8 two fields");
        run_case(1, 3, 3, -1, 0, 40, 1000, 1, 23, "R2 x6 start while busy");
        run_case(2, 4, 4, -1, 0, -1, 1000, 0, 37, "R8 x4 wrong check byte");
        run_case(3, 0, 1, -1, 1, -1, 1000, 1, 41, "R4 glitch, R6 count zero");
        run_case(2, 3, 3, 1, 0, -1, 1000, 1, 53, "R9 bad delimiter");
        run_case(0, 2, 0, -1, 0, -1, 20, 1, 67, "R10 no response");
        run_case(1, 2, 1, -1, 0, -1, 30, 1, 71, "R10 missing second field");
        run_case(0, 5, 5, -1, 0, -1, 1000, 1, 83, "R7 five fields");
        armed = 0;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule